// File: doc/BRIEF.md
# Tri-State Threshold Gain-Control Detector

This block watches a stream of digitised receiver samples and tells an off-chip analog integrator which way to move the tuner gain. One 10-bit sample arrives on every clock. Each sample is read as two's complement or as offset binary, depending on a format setting. The block takes the magnitude of each sample and smooths it with a first-order leaky average. It then compares the upper bits of that average with a small signed threshold.

The result drives one three-valued control pin. The pin drives high when the measured level is under the threshold, which charges the integrator and raises the gain. It drives low when the level is over the threshold. It floats when the level matches the threshold, so the integrator holds its voltage. The analog loop has a time constant of several milliseconds, so only a direction is needed. The pin is given as two signals, a drive enable and a drive value, and the pad cell combines them. A small write-only port sets the format and the threshold.

Top module: `agc_level_detector`

## Requirements
- R1: With format 0 (two's complement), a sample's magnitude is its absolute value. The code 0x200 (-512) gives magnitude 512 with no wrap, so a steady full-scale negative input drives the pin low against threshold 7.
- R2: With format 1 (offset binary), the sample MSB is inverted before the magnitude is taken. Code 0x200 then means zero and code 0x000 means -512.
- R3: The average register follows acc_next = acc - (acc >> AVG_SHIFT) + magnitude once per clock. The average is acc >> AVG_SHIFT.
- R4: Let level be the top THR_W bits of the average, read as an unsigned number. If level is less than the signed threshold, the pin drives high (drive enable 1, value 1).
- R5: If level is greater than the signed threshold, the pin drives low (drive enable 1, value 0).
- R6: If level equals the threshold, the pin floats: drive enable 0, and the value is held at 0.
- R7: A threshold write takes effect on the pin at the clock edge after the edge that stores it. A sample reaches the magnitude register at one edge, the average at the next edge, and the pin at the edge after that.
- R8: During reset and right after it, the format is 0, the threshold is 0, the average is 0 and the pin floats.
- R9: A write happens only when cfg_we is 1. cfg_sel 0 loads the format from cfg_wdata bit 0. cfg_sel 1 loads the threshold from all THR_W bits. While cfg_we is 0, both settings keep their values.
- R10: A negative threshold (for example 4'hF = -1) is always below the level, so the pin drives low for any input.
- R11: The average register never wraps. It stays at or below 2^(SAMPLE_W-1) << AVG_SHIFT, even under a steady full-scale input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | SAMPLE_W | Digitised input sample, one per clock |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | Setting select: 0 format, 1 threshold |
| cfg_wdata | input | THR_W | Write data (bit 0 for format, all bits for threshold) |
| agc_oe | output | 1 | Drive enable of the control pin; 0 means high impedance |
| agc_val | output | 1 | Level driven on the control pin when enabled |

## Verification
The bench keeps SAMPLE_W at 10 and THR_W at 4. This makes the level the top four bits of a 10-bit average, and the 512-magnitude corner then sits one step above the largest positive threshold. AVG_SHIFT is lowered to 3, so the average settles within a few tens of clocks. This brings the steady states into reach in short directed runs: below, above and equal, each format, a negative threshold, and the full-scale no-wrap case. A long random run then follows the exact recurrence through threshold and format changes at any point.

// File: rtl/agc_det_pkg.sv
package agc_det_pkg;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } smp_fmt_e;

    typedef enum logic {
        CSEL_FMT = 1'b0,
        CSEL_THR = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    localparam pin_drv_t DRV_HIZ       = '{oe: 1'b0, val: 1'b0};
    localparam pin_drv_t DRV_CHARGE    = '{oe: 1'b1, val: 1'b1};
    localparam pin_drv_t DRV_DISCHARGE = '{oe: 1'b1, val: 1'b0};

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
    import agc_det_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [THR_W-1:0]        cfg_wdata,
    output smp_fmt_e                fmt,
    output logic signed [THR_W-1:0] thr
);

    typedef struct packed {
        smp_fmt_e         fmt;
        logic [THR_W-1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CSEL_FMT: cfg_d.fmt = smp_fmt_e'(cfg_wdata[0]);
                CSEL_THR: cfg_d.thr = cfg_wdata;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{fmt: FMT_TWOS, thr: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fmt = cfg_q.fmt;
    assign thr = $signed(cfg_q.thr);

endmodule

// File: rtl/agc_rectifier.sv
module agc_rectifier
    import agc_det_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp,
    input  smp_fmt_e            fmt,
    output logic [SAMPLE_W-1:0] mag
);

    localparam int MSB = SAMPLE_W - 1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] mag;
    } rect_t;

    rect_t rect_d, rect_q;
    logic [SAMPLE_W-1:0] twos_v;

    always_comb begin
        twos_v      = smp;
        twos_v[MSB] = smp[MSB] ^ (fmt == FMT_OFFSET);
        rect_d      = rect_q;
        if (twos_v[MSB]) begin
            // Most negative code maps to 2^(SAMPLE_W-1), still representable unsigned
            rect_d.mag = ~twos_v + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        end else begin
            rect_d.mag = twos_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rect_q <= '0;
        end else begin
            rect_q <= rect_d;
        end
    end

    assign mag = rect_q.mag;

endmodule

// File: rtl/agc_leaky_avg.sv
module agc_leaky_avg #(
    parameter int MAG_W     = 10,
    parameter int AVG_SHIFT = 6,
    localparam int ACC_W    = MAG_W + AVG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag,
    output logic [ACC_W-1:0] acc,
    output logic [MAG_W-1:0] avg
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } avg_t;

    avg_t avg_d, avg_q;
    logic [ACC_W-1:0] leak;

    always_comb begin
        leak      = avg_q.acc >> AVG_SHIFT;
        avg_d     = avg_q;
        avg_d.acc = avg_q.acc - leak + {{AVG_SHIFT{1'b0}}, mag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_q <= '0;
        end else begin
            avg_q <= avg_d;
        end
    end

    assign acc = avg_q.acc;
    assign avg = avg_q.acc[ACC_W-1:AVG_SHIFT];

endmodule

// File: rtl/agc_thr_compare.sv
module agc_thr_compare
    import agc_det_pkg::*;
#(
    parameter int MAG_W = 10,
    parameter int THR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MAG_W-1:0]        avg,
    input  logic signed [THR_W-1:0] thr,
    output pin_drv_t                drv
);

    typedef struct packed {
        pin_drv_t drv;
    } cmp_t;

    cmp_t cmp_d, cmp_q;
    logic signed [THR_W:0] level_s;
    logic signed [THR_W:0] thr_s;

    always_comb begin
        // Threshold aligned to the top of the average: compare the upper bits only
        level_s = $signed({1'b0, avg[MAG_W-1 -: THR_W]});
        thr_s   = {thr[THR_W-1], thr};
        cmp_d   = cmp_q;
        if (level_s < thr_s) begin
            cmp_d.drv = DRV_CHARGE;
        end else if (level_s > thr_s) begin
            cmp_d.drv = DRV_DISCHARGE;
        end else begin
            cmp_d.drv = DRV_HIZ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '{drv: DRV_HIZ};
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign drv = cmp_q.drv;

endmodule

// File: rtl/agc_level_detector.sv
module agc_level_detector
    import agc_det_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int THR_W     = 4,
    parameter int AVG_SHIFT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [THR_W-1:0]    cfg_wdata,
    output logic                agc_oe,
    output logic                agc_val
);

    localparam int MAG_W = SAMPLE_W;
    localparam int ACC_W = MAG_W + AVG_SHIFT;

    smp_fmt_e                fmt_w;
    logic signed [THR_W-1:0] thr_w;
    logic [MAG_W-1:0]        mag_w;
    logic [ACC_W-1:0]        acc_w;
    logic [MAG_W-1:0]        avg_w;
    pin_drv_t                drv_w;

    agc_cfg_regs #(.THR_W(THR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fmt       (fmt_w),
        .thr       (thr_w)
    );

    agc_rectifier #(.SAMPLE_W(SAMPLE_W)) u_rect (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp_in),
        .fmt   (fmt_w),
        .mag   (mag_w)
    );

    agc_leaky_avg #(.MAG_W(MAG_W), .AVG_SHIFT(AVG_SHIFT)) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .mag   (mag_w),
        .acc   (acc_w),
        .avg   (avg_w)
    );

    agc_thr_compare #(.MAG_W(MAG_W), .THR_W(THR_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .avg   (avg_w),
        .thr   (thr_w),
        .drv   (drv_w)
    );

    assign agc_oe  = drv_w.oe;
    assign agc_val = drv_w.val;

endmodule

// File: rtl/agc_level_detector_chk.sv
module agc_level_detector_chk #(
    parameter int SAMPLE_W  = 10,
    parameter int THR_W     = 4,
    parameter int AVG_SHIFT = 6,
    localparam int ACC_W    = SAMPLE_W + AVG_SHIFT
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    fmt,
    input logic signed [THR_W-1:0] thr,
    input logic [SAMPLE_W-1:0]     mag,
    input logic [ACC_W-1:0]        acc,
    input logic [SAMPLE_W-1:0]     avg,
    input logic                    agc_oe,
    input logic                    agc_val
);

    localparam logic [ACC_W-1:0]    ACC_MAX = ACC_W'(1) << (SAMPLE_W - 1 + AVG_SHIFT);
    localparam logic [SAMPLE_W-1:0] MAG_MAX = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic signed [THR_W:0] lvl_c;
    logic signed [THR_W:0] thr_c;
    assign lvl_c = $signed({1'b0, avg[SAMPLE_W-1 -: THR_W]});
    assign thr_c = {thr[THR_W-1], thr};

    p_mag_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= MAG_MAX);

    p_leak_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> acc == $past(acc) - ($past(acc) >> AVG_SHIFT) + {{AVG_SHIFT{1'b0}}, $past(mag)});

    p_below_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_c < thr_c) |=> (agc_oe && agc_val));

    p_above_discharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_c > thr_c) |=> (agc_oe && !agc_val));

    p_equal_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_c == thr_c) |=> !agc_oe);

    p_float_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !agc_oe |-> !agc_val);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(thr) && $stable(fmt)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_MAX);

endmodule

bind agc_level_detector agc_level_detector_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .THR_W     (THR_W),
    .AVG_SHIFT (AVG_SHIFT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .fmt     (fmt_w),
    .thr     (thr_w),
    .mag     (mag_w),
    .acc     (acc_w),
    .avg     (avg_w),
    .agc_oe  (agc_oe),
    .agc_val (agc_val)
);

// File: tb/tb_agc_level_detector.sv
module tb_agc_level_detector;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 10;
    localparam int TW = 4;
    localparam int SH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] smp_in = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [TW-1:0] cfg_wdata = '0;
    logic          agc_oe;
    logic          agc_val;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_fmt, m_thr, m_mag, m_acc, m_oe, m_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    agc_level_detector #(.SAMPLE_W(SW), .THR_W(TW), .AVG_SHIFT(SH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_in    (smp_in),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .agc_oe    (agc_oe),
        .agc_val   (agc_val)
    );

    function automatic int ref_mag(logic [SW-1:0] s, int fmt);
        logic signed [SW-1:0] v;
        int iv;
        v = s;
        if (fmt != 0) v[SW-1] = ~v[SW-1];
        iv = int'(v);
        return (iv < 0) ? -iv : iv;
    endfunction

    function automatic int ref_dir(int acc, int thr);
        int lvl;
        lvl = (acc >> SH) >> (SW - TW);
        if (lvl < thr) return 3;   // drive high
        if (lvl > thr) return 2;   // drive low
        return 0;                  // float
    endfunction

    task automatic check(string req, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: pin {oe,val} actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge
    task automatic step(logic [SW-1:0] s, logic we, logic sel, logic [TW-1:0] wd, string tag);
        int d;
        string req;
        smp_in = s; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        @(posedge clk);
        d     = ref_dir(m_acc, m_thr);
        m_oe  = d >> 1;
        m_val = d & 1;
        m_acc = m_acc - (m_acc >> SH) + m_mag;
        m_mag = ref_mag(s, m_fmt);
        if (we) begin
            if (sel) m_thr = int'($signed(wd));
            else     m_fmt = int'(wd[0]);
        end
        #1;
        if (tag != "") req = tag;
        else if (d == 3) req = "R4";
        else if (d == 2) req = "R5";
        else req = "R6";
        check(req, {30'd0, agc_oe, agc_val}, (m_oe << 1) | m_val);
        @(negedge clk);
    endtask

    task automatic hold(logic [SW-1:0] s, int n, string last_tag);
        for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, '0, (i == n-1) ? last_tag : "");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd7719));
        m_fmt = 0; m_thr = 0; m_mag = 0; m_acc = 0; m_oe = 0; m_val = 0;
        repeat (3) @(negedge clk);
        // R8: reset state floats the pin
        check("R8", {30'd0, agc_oe, agc_val}, 0);
        rst_n = 1'b1;
        hold('0, 4, "R8");
        check("R8", {30'd0, agc_oe, agc_val}, 0);

        // R1 / R11: full-scale negative two's complement against threshold 7
        step(10'h200, 1'b1, 1'b1, 4'd7, "");
        hold(10'h200, 120, "R1");
        check("R11", {30'd0, agc_oe, agc_val}, 2);

        // R4: decay to zero input, level below threshold 7
        hold(10'h000, 80, "R4");
        check("R4", {30'd0, agc_oe, agc_val}, 3);

        // R6: magnitude 128 gives level 2, threshold 2
        step(10'd128, 1'b1, 1'b1, 4'd2, "");
        hold(10'd128, 80, "R6");
        check("R6", {30'd0, agc_oe, agc_val}, 0);

        // R5: negative value -200 gives level 3 above threshold 2
        hold(10'h338, 80, "R5");
        check("R5", {30'd0, agc_oe, agc_val}, 2);

        // R2: offset binary, code 0x200 is zero, code 0x000 is full scale
        step(10'h200, 1'b1, 1'b0, 4'd1, "");
        hold(10'h200, 80, "R2");
        check("R2", {30'd0, agc_oe, agc_val}, 3);
        hold(10'h000, 80, "R2");
        check("R2", {30'd0, agc_oe, agc_val}, 2);

        // R10: back to two's complement, zero input, threshold -1
        step(10'h000, 1'b1, 1'b0, 4'd0, "");
        step(10'h000, 1'b1, 1'b1, 4'hF, "");
        hold(10'h000, 80, "R10");
        check("R10", {30'd0, agc_oe, agc_val}, 2);

        // R9: write data and select toggling without strobe change nothing
        for (int i = 0; i < 20; i++) step(10'h000, 1'b0, i[0], 4'd7, "R9");
        check("R9", {30'd0, agc_oe, agc_val}, 2);

        // R7: threshold write reaches the pin one edge after it is stored
        step(10'h000, 1'b1, 1'b1, 4'd1, "R7");
        check("R7", {30'd0, agc_oe, agc_val}, 2);
        step(10'h000, 1'b0, 1'b0, '0, "R7");
        check("R7", {30'd0, agc_oe, agc_val}, 3);

        // R3: random samples with occasional setting writes
        for (int i = 0; i < 3000; i++) begin
            logic [SW-1:0] s;
            logic          we;
            s  = SW'($urandom);
            if (i % 500 < 250) s = SW'($urandom_range(0, 40)) - SW'(20);
            we = ($urandom_range(0, 15) == 0);
            step(s, we, 1'($urandom), TW'($urandom), "R3");
        end

        summary();
    end

endmodule